// File: doc/BRIEF.md
# Burst-Counted SPI Master

This block is an SPI master controlled through a small register bus. A transaction is described by two counters: the burst count gives the total number of bytes clocked on the wire, and the transfer count gives how many of those leading bytes are taken from the transmit FIFO. Once the transfer count is used up, the master shifts out filler bytes of all ones. Every byte shifted in on MISO is written to the receive FIFO, including the bytes that arrive while command bytes are still going out. Software therefore discards the leading bytes itself.

A typical flash read pushes a command byte and three address bytes into the transmit FIFO. Software then sets the transfer count to four and the burst count to four plus the payload length, and sets the exchange bit. It polls until that bit clears and drains the receive FIFO. Chip select stays low for the whole burst. The serial clock follows SPI mode 0, most significant bit first. The clock rate is set by a divider register with two modes: a linear mode and a power-of-two mode.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, the control register at offset 0x08 reads 0 and the status register at offset 0x28 reads 0. spi_cs_n is high and spi_sclk is low.
- R2: The exchange bit (control bit 10) is set by writing 1 to it. A burst starts only while enable (bit 0) and master (bit 1) are both set. The exchange bit reads 1 until the last byte of the burst completes and then clears by itself.
- R3: A burst clocks exactly burst-count (offset 0x20) bytes, giving 8 rising SCLK edges per byte. spi_cs_n stays low from the first edge to the last and returns high after the burst.
- R4: The first transfer-count (offset 0x24) bytes of a burst are popped from the TX FIFO; every later byte, and any byte needed while the TX FIFO is empty, is 0xFF. Bits are sent MSB first in mode 0: MOSI is steady while SCLK is high, and changes only after a falling edge.
- R5: Every byte received during the burst is pushed into the RX FIFO, including bytes received during the TX-FIFO bytes. Status bits [6:0] give the RX FIFO byte count.
- R6: A byte read of offset 0x00 pops one RX byte into bits [7:0]. A word read pops up to four bytes, with the oldest in bits [7:0]. Bytes that are not present read as 0.
- R7: Writing 1 to control bit 8 empties the TX FIFO, and writing 1 to control bit 9 empties the RX FIFO. Each of these bits clears itself one cycle later.
- R8: Clock control (offset 0x1C) with bit 12 set divides the system clock by 2*(N+1), where N is bits [7:0]. With bit 12 clear it divides by 2^(M+1), where M is bits [11:8]. SCLK high and low phases each last half the divisor.
- R9: Each FIFO holds 64 bytes. Writes to TX (offset 0x04, data in bits [7:0]) and received bytes beyond that are dropped. Status bits [22:16] give the TX FIFO byte count.
- R10: Setting the exchange bit with a burst count of 0 clears the exchange bit without lowering spi_cs_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (RX reads pop) |
| bus_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Slave data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The bench builds the block with its default parameters: 64-byte FIFOs and 16-bit counters. With these values, a single 66-byte burst at the fastest divider overruns the receive FIFO in about a thousand cycles. It also lets the transmit FIFO be filled past its limit with 65 writes. The divider settings used are 2, 4, 8 and 32. They cover both clock modes, and each high phase is measured in system cycles. A bench slave model returns a known byte sequence, so the command-phase bytes and the payload bytes can each be told apart in the receive FIFO.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam logic [7:0] OFS_RXD  = 8'h00;
  localparam logic [7:0] OFS_TXD  = 8'h04;
  localparam logic [7:0] OFS_CTL  = 8'h08;
  localparam logic [7:0] OFS_CLK  = 8'h1C;
  localparam logic [7:0] OFS_BCNT = 8'h20;
  localparam logic [7:0] OFS_TCNT = 8'h24;
  localparam logic [7:0] OFS_STAT = 8'h28;

  localparam int CTL_EN    = 0;
  localparam int CTL_MST   = 1;
  localparam int CTL_TXCLR = 8;
  localparam int CTL_RXCLR = 9;
  localparam int CTL_GO    = 10;
  localparam int CLK_LIN   = 12;
  localparam int CLK_W     = 13;

  typedef enum logic {ENG_IDLE, ENG_SHIFT} eng_state_t;

  typedef struct packed {
    logic go;
    logic rxclr;
    logic txclr;
    logic mst;
    logic en;
  } ctl_t;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int PEEK  = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [7:0]        wdata,
  input  logic [2:0]        pop_n,
  output logic [PEEK*8-1:0] peek,
  output logic [CW-1:0]     count
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d, pop_w, pop_amt;
  logic          do_push;

  assign do_push = push && (cnt_q != CW'(DEPTH));
  assign pop_w   = CW'(pop_n);
  assign pop_amt = (pop_w > cnt_q) ? cnt_q : pop_w;

  always_comb begin
    if (flush) begin
      cnt_d = '0;
      rd_d  = '0;
      wr_d  = '0;
    end else begin
      cnt_d = cnt_q + CW'(do_push) - pop_amt;
      rd_d  = rd_q + AW'(pop_amt);
      wr_d  = wr_q + AW'(do_push);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      rd_q  <= rd_d;
      wr_q  <= wr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_q] <= wdata;
  end

  for (genvar i = 0; i < PEEK; i++) begin : g_peek
    assign peek[i*8 +: 8] = mem[rd_q + AW'(i)];
  end

  assign count = cnt_q;

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CW    = 7,
  localparam int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] bcnt,
  input  logic [CNT_W-1:0] tcnt,
  input  logic [CLK_W-1:0] clkcfg,
  input  logic [7:0]       tx_head,
  input  logic [CW-1:0]    tx_cnt,
  input  logic             miso,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [7:0]       rx_data,
  output logic             done,
  output logic             busy,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n
);
  eng_state_t       st_q, st_d;
  logic [DIV_W-1:0] div_q, div_d, half;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       txsh_q, txsh_d, rxsh_q, rxsh_d;
  logic [CNT_W-1:0] ld_q, ld_d, load_idx;
  logic             sclk_q, sclk_d, cs_q, tick, load;

  assign half = clkcfg[CLK_LIN] ? (DIV_W'(clkcfg[7:0]) + DIV_W'(1))
                                : (DIV_W'(1) << clkcfg[11:8]);
  assign tick = (st_q == ENG_SHIFT) && (div_q == half - DIV_W'(1));

  always_comb begin
    st_d     = st_q;
    div_d    = div_q;
    bit_d    = bit_q;
    txsh_d   = txsh_q;
    rxsh_d   = rxsh_q;
    ld_d     = ld_q;
    sclk_d   = sclk_q;
    tx_pop   = 1'b0;
    rx_push  = 1'b0;
    done     = 1'b0;
    load     = 1'b0;
    load_idx = ld_q;
    case (st_q)
      ENG_IDLE: begin
        if (start) begin
          if (bcnt == '0) begin
            done = 1'b1;
          end else begin
            load     = 1'b1;
            load_idx = '0;
            ld_d     = CNT_W'(1);
            st_d     = ENG_SHIFT;
            div_d    = '0;
            bit_d    = '0;
            sclk_d   = 1'b0;
          end
        end
      end
      default: begin
        if (!tick) begin
          div_d = div_q + DIV_W'(1);
        end else begin
          div_d = '0;
          if (!sclk_q) begin
            sclk_d = 1'b1;
            rxsh_d = {rxsh_q[6:0], miso};
          end else begin
            sclk_d = 1'b0;
            if (bit_q == 3'd7) begin
              rx_push = 1'b1;
              bit_d   = '0;
              if (ld_q == bcnt) begin
                done = 1'b1;
                st_d = ENG_IDLE;
              end else begin
                load = 1'b1;
                ld_d = ld_q + CNT_W'(1);
              end
            end else begin
              bit_d  = bit_q + 3'd1;
              txsh_d = {txsh_q[6:0], 1'b1};
            end
          end
        end
      end
    endcase
    if (load) begin
      if ((load_idx < tcnt) && (tx_cnt != '0)) begin
        txsh_d = tx_head;
        tx_pop = 1'b1;
      end else begin
        txsh_d = 8'hFF;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      div_q  <= '0;
      bit_q  <= '0;
      txsh_q <= 8'hFF;
      rxsh_q <= '0;
      ld_q   <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      st_q   <= st_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      txsh_q <= txsh_d;
      rxsh_q <= rxsh_d;
      ld_q   <= ld_d;
      sclk_q <= sclk_d;
      cs_q   <= (st_d == ENG_IDLE);
    end
  end

  assign rx_data = rxsh_q;
  assign busy    = (st_q != ENG_IDLE);
  assign sclk    = sclk_q;
  assign mosi    = txsh_q[7];
  assign cs_n    = cs_q;

  assert_sclk_inside_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_q && cs_q));
  assert_mosi_steady_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(txsh_q[7]));
  assert_byte_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_SHIFT) |-> ((ld_q != '0) && (ld_q <= bcnt)));
endmodule

// File: rtl/spi_burst_regs.sv
module spi_burst_regs
  import spi_burst_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CW    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_word,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [CW-1:0]    tx_cnt,
  input  logic [CW-1:0]    rx_cnt,
  input  logic [31:0]      rx_peek,
  input  logic             eng_done,
  input  logic             eng_busy,
  output logic             start,
  output logic             tx_push,
  output logic [7:0]       tx_wdata,
  output logic [2:0]       rx_pop_n,
  output logic             tx_flush,
  output logic             rx_flush,
  output logic [CNT_W-1:0] bcnt,
  output logic [CNT_W-1:0] tcnt,
  output logic [CLK_W-1:0] clkcfg
);
  ctl_t             ctl_q, ctl_d;
  logic [CLK_W-1:0] clk_q, clk_d;
  logic [CNT_W-1:0] bc_q, bc_d, tc_q, tc_d;
  logic             wr_ctl, rd_rx;
  logic [2:0]       avail4, nread;
  logic [31:0]      ctl_word;

  assign wr_ctl = bus_wr && (bus_addr == OFS_CTL);
  assign rd_rx  = bus_rd && (bus_addr == OFS_RXD);

  always_comb begin
    ctl_d       = ctl_q;
    ctl_d.txclr = 1'b0;
    ctl_d.rxclr = 1'b0;
    if (eng_done) ctl_d.go = 1'b0;
    clk_d = clk_q;
    bc_d  = bc_q;
    tc_d  = tc_q;
    if (wr_ctl) begin
      ctl_d.en    = bus_wdata[CTL_EN];
      ctl_d.mst   = bus_wdata[CTL_MST];
      ctl_d.txclr = bus_wdata[CTL_TXCLR];
      ctl_d.rxclr = bus_wdata[CTL_RXCLR];
      ctl_d.go    = ctl_d.go | bus_wdata[CTL_GO];
    end
    if (bus_wr && (bus_addr == OFS_CLK))  clk_d = bus_wdata[CLK_W-1:0];
    if (bus_wr && (bus_addr == OFS_BCNT)) bc_d  = bus_wdata[CNT_W-1:0];
    if (bus_wr && (bus_addr == OFS_TCNT)) tc_d  = bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      clk_q <= '0;
      bc_q  <= '0;
      tc_q  <= '0;
    end else begin
      ctl_q <= ctl_d;
      clk_q <= clk_d;
      bc_q  <= bc_d;
      tc_q  <= tc_d;
    end
  end

  assign start    = ctl_q.go && ctl_q.en && ctl_q.mst && !eng_busy;
  assign tx_push  = bus_wr && (bus_addr == OFS_TXD);
  assign tx_wdata = bus_wdata[7:0];
  assign tx_flush = ctl_q.txclr;
  assign rx_flush = ctl_q.rxclr;
  assign bcnt     = bc_q;
  assign tcnt     = tc_q;
  assign clkcfg   = clk_q;

  assign avail4   = (rx_cnt >= CW'(4)) ? 3'd4 : 3'(rx_cnt);
  assign nread    = bus_word ? avail4 : ((rx_cnt != '0) ? 3'd1 : 3'd0);
  assign rx_pop_n = rd_rx ? nread : 3'd0;

  always_comb begin
    ctl_word            = '0;
    ctl_word[CTL_EN]    = ctl_q.en;
    ctl_word[CTL_MST]   = ctl_q.mst;
    ctl_word[CTL_TXCLR] = ctl_q.txclr;
    ctl_word[CTL_RXCLR] = ctl_q.rxclr;
    ctl_word[CTL_GO]    = ctl_q.go;
    bus_rdata = '0;
    case (bus_addr)
      OFS_RXD: begin
        for (int i = 0; i < 4; i++) begin
          if (3'(i) < nread) bus_rdata[i*8 +: 8] = rx_peek[i*8 +: 8];
        end
      end
      OFS_CTL:  bus_rdata = ctl_word;
      OFS_CLK:  bus_rdata = 32'(clk_q);
      OFS_BCNT: bus_rdata = 32'(bc_q);
      OFS_TCNT: bus_rdata = 32'(tc_q);
      OFS_STAT: bus_rdata = 32'(rx_cnt) | (32'(tx_cnt) << 16);
      default:  bus_rdata = '0;
    endcase
  end

  assert_go_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !wr_ctl) |=> !ctl_q.go);
  assert_txclr_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.txclr && !wr_ctl) |=> !ctl_q.txclr);
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = 16,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic        bus_word,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n
);
  logic             rst_meta, rst_sync;
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic [31:0]      tx_peek, rx_peek;
  logic             start, tx_push, tx_flush, rx_flush, tx_pop, rx_push;
  logic             eng_done, eng_busy;
  logic [7:0]       tx_wdata, rx_data;
  logic [2:0]       rx_pop_n;
  logic [CNT_W-1:0] bcnt, tcnt;
  logic [CLK_W-1:0] clkcfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  spi_burst_regs #(.CNT_W(CNT_W), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_sync),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .rx_peek(rx_peek),
    .eng_done(eng_done), .eng_busy(eng_busy), .start(start),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .rx_pop_n(rx_pop_n),
    .tx_flush(tx_flush), .rx_flush(rx_flush),
    .bcnt(bcnt), .tcnt(tcnt), .clkcfg(clkcfg)
  );

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .PEEK(4)) u_txf (
    .clk(clk), .rst_n(rst_sync), .flush(tx_flush),
    .push(tx_push), .wdata(tx_wdata), .pop_n({2'b00, tx_pop}),
    .peek(tx_peek), .count(tx_cnt)
  );

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .PEEK(4)) u_rxf (
    .clk(clk), .rst_n(rst_sync), .flush(rx_flush),
    .push(rx_push), .wdata(rx_data), .pop_n(rx_pop_n),
    .peek(rx_peek), .count(rx_cnt)
  );

  spi_burst_engine #(.CNT_W(CNT_W), .CW(CW)) u_eng (
    .clk(clk), .rst_n(rst_sync), .start(start),
    .bcnt(bcnt), .tcnt(tcnt), .clkcfg(clkcfg),
    .tx_head(tx_peek[7:0]), .tx_cnt(tx_cnt), .miso(spi_miso),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
    .done(eng_done), .busy(eng_busy),
    .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n)
  );
endmodule

// File: tb/sim_spi_burst_master.sv
module sim_spi_burst_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_word = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi, spi_cs_n;
  logic        spi_miso = 1'b0;

  int total = 0, bad = 0, cycles = 0;
  int rises = 0, cs_falls = 0, hi_run = 0, last_hi = 0;
  logic [7:0] exp_mosi[$];
  logic [7:0] exp_rx[$];
  logic [7:0] stage[$];
  logic [7:0] mo = '0, mi = '0, sl_byte = '0, sl_seed = 8'h5A;
  int nb = 0, sl_bit = 0;
  bit finished = 0;

  spi_burst_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_word(bus_word), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
        finish_run();
      end
    end
  end

  // slave model: returns a known byte sequence, MSB first, mode 0
  function automatic logic [7:0] next_slave();
    sl_seed = sl_seed * 8'd5 + 8'd3;
    return sl_seed;
  endfunction

  always @(negedge spi_cs_n) begin
    cs_falls++;
    sl_byte = next_slave();
    sl_bit = 0;
    spi_miso = sl_byte[7];
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n) begin
      sl_bit++;
      if (sl_bit == 8) begin
        sl_bit = 0;
        sl_byte = next_slave();
      end
      spi_miso = sl_byte[7 - sl_bit];
    end
  end

  // monitor: scoreboard for MOSI bytes, records received bytes
  always @(posedge spi_sclk) begin
    rises++;
    mo = {mo[6:0], spi_mosi};
    mi = {mi[6:0], spi_miso};
    nb++;
    if (nb == 8) begin
      nb = 0;
      if (exp_mosi.size() == 0) begin
        chk(1'b0, "R4 unexpected mosi byte", mo, 0);
      end else begin
        logic [7:0] e;
        e = exp_mosi.pop_front();
        chk(mo == e, "R4 mosi byte", mo, e);
      end
      exp_rx.push_back(mi);
    end
  end

  always @(negedge clk) begin
    if (spi_sclk) hi_run++;
    else if (hi_run != 0) begin
      last_hi = hi_run;
      hi_run = 0;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_word = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input bit word, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_word = word; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    c = 32'h400;
    while (c[10]) rd(8'h08, 1'b1, c);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_burst(input int bc, input int tc, input int cfg, input int half);
    int used;
    used = 0;
    wr(8'h1C, cfg);
    wr(8'h20, bc);
    wr(8'h24, tc);
    foreach (stage[i]) wr(8'h04, {24'h0, stage[i]});
    for (int k = 0; k < bc; k++) begin
      if (k < tc && used < stage.size()) begin
        exp_mosi.push_back(stage[used]);
        used++;
      end else exp_mosi.push_back(8'hFF);
    end
    stage.delete();
    rises = 0;
    last_hi = 0;
    wr(8'h08, 32'h403);
    wait_idle();
    chk(rises == bc * 8, "R3 sclk rises", rises, bc * 8);
    chk(spi_cs_n == 1'b1, "R3 cs released", spi_cs_n, 1);
    chk(exp_mosi.size() == 0, "R4 bytes left unsent", exp_mosi.size(), 0);
    if (bc > 0) chk(last_hi == half, "R8 sclk half period", last_hi, half);
  endtask

  initial begin
    logic [31:0] d;
    logic [7:0]  e;
    logic [31:0] ew;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h08, 1'b1, d); chk(d == 0, "R1 ctl reset", d, 0);
    rd(8'h28, 1'b1, d); chk(d == 0, "R1 status reset", d, 0);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 pins idle", {spi_cs_n, spi_sclk}, 2);

    // R2 exchange held off while disabled; R4 filler bytes
    wr(8'h1C, 32'h1000);
    wr(8'h20, 2);
    wr(8'h24, 0);
    wr(8'h08, 32'h400);
    repeat (40) @(negedge clk);
    chk(cs_falls == 0, "R2 no burst while disabled", cs_falls, 0);
    rd(8'h08, 1'b1, d); chk(d == 32'h400, "R2 go bit pending", d, 32'h400);
    exp_mosi.push_back(8'hFF); exp_mosi.push_back(8'hFF);
    rises = 0;
    wr(8'h08, 32'h003);
    wait_idle();
    chk(rises == 16, "R2 burst runs once enabled", rises, 16);
    rd(8'h08, 1'b1, d); chk(d == 32'h3, "R2 go self-cleared", d, 3);
    chk(exp_mosi.size() == 0, "R4 filler bytes", exp_mosi.size(), 0);
    wr(8'h08, 32'h203);
    exp_rx.delete();

    // R5/R6 command + payload burst, divide by 4
    stage = '{8'h03, 8'h12, 8'h34, 8'h56};
    run_burst(10, 4, 32'h1001, 2);
    rd(8'h28, 1'b1, d); chk(d[6:0] == 10, "R5 rx count incl command phase", d[6:0], 10);
    rd(8'h00, 1'b1, d);
    ew = {exp_rx[3], exp_rx[2], exp_rx[1], exp_rx[0]};
    chk(d == ew, "R6 word read order", d, ew);
    repeat (4) void'(exp_rx.pop_front());
    for (int k = 0; k < 6; k++) begin
      rd(8'h00, 1'b0, d);
      e = exp_rx.pop_front();
      chk(d == {24'h0, e}, "R6 byte read", d, e);
    end
    rd(8'h28, 1'b1, d); chk(d == 0, "R5 fifos drained", d, 0);

    // R8 divide by 32, partial word read
    stage = '{8'hA5};
    run_burst(2, 1, 32'h100F, 16);
    rd(8'h00, 1'b1, d);
    ew = {16'h0, exp_rx[1], exp_rx[0]};
    chk(d == ew, "R6 short word read", d, ew);
    exp_rx.delete();
    rd(8'h28, 1'b1, d); chk(d[6:0] == 0, "R6 short word pops all", d[6:0], 0);

    // R8 power-of-two mode: M=2 -> divide by 8
    stage = '{8'h81, 8'h7E, 8'hC3};
    run_burst(3, 3, 32'h0200, 4);
    for (int k = 0; k < 3; k++) begin
      rd(8'h00, 1'b0, d);
      e = exp_rx.pop_front();
      chk(d[7:0] == e, "R5 rx byte pow2 mode", d[7:0], e);
    end

    // R9 rx overflow: 66 bytes into 64-byte fifo
    run_burst(66, 0, 32'h1000, 1);
    rd(8'h28, 1'b1, d); chk(d[6:0] == 64, "R9 rx capped at depth", d[6:0], 64);
    begin
      int errs;
      errs = 0;
      for (int k = 0; k < 64; k++) begin
        rd(8'h00, 1'b0, d);
        e = exp_rx.pop_front();
        if (d[7:0] != e) errs++;
      end
      chk(errs == 0, "R9 first 64 rx bytes kept", errs, 0);
    end
    exp_rx.delete();

    // R10 zero-length burst
    begin
      int f0;
      f0 = cs_falls;
      wr(8'h20, 0);
      wr(8'h08, 32'h403);
      repeat (3) @(negedge clk);
      rd(8'h08, 1'b1, d); chk(d[10] == 1'b0, "R10 go clears with zero count", d[10], 0);
      chk(cs_falls == f0, "R10 cs untouched", cs_falls - f0, 0);
    end

    // R9/R7 tx overflow then tx reset
    for (int k = 0; k < 65; k++) wr(8'h04, k);
    rd(8'h28, 1'b1, d); chk(d[22:16] == 64, "R9 tx capped at depth", d[22:16], 64);
    wr(8'h08, 32'h103);
    rd(8'h28, 1'b1, d); chk(d[22:16] == 0, "R7 tx reset empties", d[22:16], 0);
    rd(8'h08, 1'b1, d); chk(d == 32'h3, "R7 reset bit self-clears", d, 3);

    // R7 rx reset
    run_burst(3, 0, 32'h1000, 1);
    rd(8'h28, 1'b1, d); chk(d[6:0] == 3, "R5 rx count", d[6:0], 3);
    wr(8'h08, 32'h203);
    rd(8'h28, 1'b1, d); chk(d[6:0] == 0, "R7 rx reset empties", d[6:0], 0);
    rd(8'h08, 1'b1, d); chk(d[9] == 1'b0, "R7 rx reset bit clears", d[9], 0);
    exp_rx.delete();

    finish_run();
  end
endmodule